// File: doc/BRIEF.md
# Programmable-Rate Third-Order Sinc Decimator

This block takes the single-bit stream of an oversampling modulator and turns it into full-precision words at a lower rate. The filter is a third-order sinc, built as three cascaded integrators that run at the input rate and three differencing stages that run at the decimated rate. One clock edge takes one modulator bit. A bit of 1 counts as +1 and a bit of 0 counts as −1.

A 12-bit rate code sets the decimation factor R. It is taken in by a single-cycle load strobe. The factor fixes the output word rate, and the first response null sits at that same rate. The −3 dB corner follows at about 0.262 of it. Usable factors run from 40 to 4095, a span of about 100 to 1.

After a reset or a new rate load, the filter history is cleared. The first three decimated results are withheld while the filter settles, and the output word keeps its previous value during that time. Each valid word after that comes with a one-cycle ready pulse.

Top module: `sinc3_decim`

## Requirements
- R1: While reset is high and in the cycle after it, dataOut is 0 and dataReady is 0. The decimation factor after reset is 64.
- R2: A modulator bit of 1 enters the filter as +1 and a bit of 0 as −1. A settled output for a steady stream of ones is +R³, and for a steady stream of zeros it is −R³.
- R3: Samples are numbered s = 0, 1, 2, … from the first edge after reset release or after the load edge. Output number m is produced from the sample at s = (m+1)·R−1. It equals Σ h[k]·x[(m+1)·R−1−k] for k = 0 … 3R−3, where h is the R-wide boxcar convolved with itself three times and x is 0 before s = 0. It appears on dataOut, with dataReady high, in the cycle after the edge that took that sample.
- R4: The decimation factor equals the rate code for codes 40 to 4095. Any code below 40 gives a factor of 40.
- R5: Outputs m = 0, 1 and 2 after a reset or a load give no ready pulse, and dataOut keeps its previous value through them.
- R6: dataReady is high for one cycle per valid output and is never high in any other cycle. Two pulses are exactly R cycles apart.
- R7: On a load edge the modulator bit is discarded and all filter history is cleared. The last valid output stays on dataOut until the first valid output at the new rate.
- R8: At R = 4095 a full-scale stream gives exactly ±4095³ with no wrap-around.
- R9: A load that arrives part-way through a decimation frame restarts sample numbering at the new rate. The partial frame produces no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one modulator bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| modBit | input | 1 | Modulator output bit |
| loadRate | input | 1 | Single-cycle strobe that takes rateWord |
| rateWord | input | 12 | Decimation factor code |
| dataOut | output | 38 | Signed filtered word, two's complement, gain R³ |
| dataReady | output | 1 | One-cycle pulse marking a new valid dataOut |

## Verification
The bench compares each output against a convolution with the cubed-boxcar kernel that the bench computes itself. Several bit patterns are used, so a design with a misaligned frame counter, a wrong ±1 mapping or an off-by-one comb delay shows a wrong value on the first checked word. It counts the withheld outputs after every reset and load. A design that releases the first, unsettled words, or that lets dataOut move during settling, is caught at those frame boundaries. A load mid-frame with a deliberately wrong bit at the load edge exposes a design that keeps old history or takes the load-edge bit. Rate codes below the floor, and the largest code at full scale, catch a missing clamp and an accumulator that is too narrow and wraps.

// File: rtl/sinc3_decim_pkg.sv
package sinc3_decim_pkg;

  // Per-cycle strobes from the control section to the datapath
  typedef struct packed {
    logic clear;   // wipe integrator and comb history (rate load)
    logic take;    // accept the current modulator bit into the integrators
    logic decim;   // frame end: advance the comb section
    logic emit;    // frame end after settling: update the output word
  } ctlStrobes_t;

endpackage

// File: rtl/sinc3_decim_ctrl.sv
module sinc3_decim_ctrl
  import sinc3_decim_pkg::*;
#(
  parameter int RATE_W       = 12,
  parameter int ORDER        = 3,
  parameter int MIN_RATE     = 40,
  parameter int DEFAULT_RATE = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadRate,
  input  logic [RATE_W-1:0] rateWord,
  output ctlStrobes_t       strobes,
  output logic              dataReady
);

  localparam int SET_W = $clog2(ORDER + 1);
  localparam logic [RATE_W-1:0] MIN_CODE = RATE_W'(MIN_RATE);
  localparam logic [RATE_W-1:0] DEF_CODE = RATE_W'(DEFAULT_RATE);

  logic [RATE_W-1:0] rateReg;
  logic [RATE_W-1:0] frameCnt;
  logic [SET_W-1:0]  settleCnt;
  logic [RATE_W-1:0] rateClamped;
  logic              frameEnd;
  logic              settled;

  assign rateClamped = (rateWord < MIN_CODE) ? MIN_CODE : rateWord;
  assign frameEnd    = (frameCnt == rateReg - RATE_W'(1));
  assign settled     = (settleCnt == SET_W'(ORDER));

  always_comb begin
    strobes.clear = loadRate;
    strobes.take  = !loadRate;
    strobes.decim = !loadRate && frameEnd;
    strobes.emit  = !loadRate && frameEnd && settled;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rateReg   <= DEF_CODE;
      frameCnt  <= '0;
      settleCnt <= '0;
      dataReady <= 1'b0;
    end else if (loadRate) begin
      rateReg   <= rateClamped;
      frameCnt  <= '0;
      settleCnt <= '0;
      dataReady <= 1'b0;
    end else begin
      dataReady <= 1'b0;
      if (frameEnd) begin
        frameCnt <= '0;
        if (settled) dataReady <= 1'b1;
        else         settleCnt <= settleCnt + SET_W'(1);
      end else begin
        frameCnt <= frameCnt + RATE_W'(1);
      end
    end
  end

endmodule

// File: rtl/sinc3_decim_path.sv
module sinc3_decim_path
  import sinc3_decim_pkg::*;
#(
  parameter int ORDER = 3,
  parameter int ACC_W = 38
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             modBit,
  input  ctlStrobes_t      strobes,
  output logic [ACC_W-1:0] dataOut
);

  logic signed [ACC_W-1:0] xIn;
  logic signed [ACC_W-1:0] integ   [ORDER];
  logic signed [ACC_W-1:0] intNext [ORDER];
  logic signed [ACC_W-1:0] combLink[ORDER+1];
  logic signed [ACC_W-1:0] combDly [ORDER];

  // 1 -> +1, 0 -> -1 in two's complement
  assign xIn = {{(ACC_W-1){~modBit}}, 1'b1};

  for (genvar g = 0; g < ORDER; g++) begin : g_integ
    if (g == 0) begin : g_first
      assign intNext[g] = integ[g] + xIn;
    end else begin : g_next
      assign intNext[g] = integ[g] + intNext[g-1];
    end
  end

  assign combLink[0] = intNext[ORDER-1];
  for (genvar g = 0; g < ORDER; g++) begin : g_comb
    assign combLink[g+1] = combLink[g] - combDly[g];
  end

  always_ff @(posedge clk) begin
    if (rst || strobes.clear) begin
      for (int k = 0; k < ORDER; k++) begin
        integ[k]   <= '0;
        combDly[k] <= '0;
      end
    end else begin
      if (strobes.take) begin
        for (int k = 0; k < ORDER; k++) integ[k] <= intNext[k];
      end
      if (strobes.decim) begin
        for (int k = 0; k < ORDER; k++) combDly[k] <= combLink[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               dataOut <= '0;
    else if (strobes.emit) dataOut <= combLink[ORDER];
  end

endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim
  import sinc3_decim_pkg::*;
#(
  parameter int RATE_W       = 12,
  parameter int ORDER        = 3,
  parameter int MIN_RATE     = 40,
  parameter int DEFAULT_RATE = 64,
  parameter int ACC_W        = 2 + ORDER * RATE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              modBit,
  input  logic              loadRate,
  input  logic [RATE_W-1:0] rateWord,
  output logic [ACC_W-1:0]  dataOut,
  output logic              dataReady
);

  ctlStrobes_t strobes;

  sinc3_decim_ctrl #(
    .RATE_W(RATE_W), .ORDER(ORDER),
    .MIN_RATE(MIN_RATE), .DEFAULT_RATE(DEFAULT_RATE)
  ) u_ctrl (
    .clk(clk), .rst(rst), .loadRate(loadRate), .rateWord(rateWord),
    .strobes(strobes), .dataReady(dataReady)
  );

  sinc3_decim_path #(.ORDER(ORDER), .ACC_W(ACC_W)) u_path (
    .clk(clk), .rst(rst), .modBit(modBit), .strobes(strobes), .dataOut(dataOut)
  );

endmodule

// File: rtl/sinc3_decim_chk.sv
module sinc3_decim_chk #(
  parameter int RATE_W   = 12,
  parameter int ORDER    = 3,
  parameter int MIN_RATE = 40,
  parameter int ACC_W    = 38
) (
  input logic              clk,
  input logic              rst,
  input logic              loadRate,
  input logic [ACC_W-1:0]  dataOut,
  input logic              dataReady
);

  localparam longint MAX_MAG = longint'((2**RATE_W) - 1) ** ORDER;

  logic [RATE_W:0] gapCnt;
  logic            seenReady;

  always_ff @(posedge clk) begin
    if (rst || loadRate) begin
      gapCnt    <= '0;
      seenReady <= 1'b0;
    end else if (dataReady) begin
      gapCnt    <= (RATE_W+1)'(1);
      seenReady <= 1'b1;
    end else if (gapCnt != '1) begin
      gapCnt    <= gapCnt + (RATE_W+1)'(1);
    end
  end

  // R6
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dataReady |=> !dataReady);

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(dataOut) |-> dataReady);

  // R7
  load_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    loadRate |=> !dataReady);

  // R8
  out_range_chk: assert property (@(posedge clk) disable iff (rst)
    dataReady |-> (longint'($signed(dataOut)) <= MAX_MAG &&
                   longint'($signed(dataOut)) >= -MAX_MAG));

  // R4
  ready_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (dataReady && seenReady) |-> (gapCnt >= (RATE_W+1)'(MIN_RATE)));

endmodule

bind sinc3_decim sinc3_decim_chk #(
  .RATE_W(RATE_W), .ORDER(ORDER), .MIN_RATE(MIN_RATE), .ACC_W(ACC_W)
) u_chk (
  .clk(clk), .rst(rst), .loadRate(loadRate),
  .dataOut(dataOut), .dataReady(dataReady)
);

// File: tb/sinc3_decim_bench.sv
module sinc3_decim_bench;

  localparam int RATE_W = 12;
  localparam int ACC_W  = 38;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              modBit = 1'b0;
  logic              loadRate = 1'b0;
  logic [RATE_W-1:0] rateWord = '0;
  logic [ACC_W-1:0]  dataOut;
  logic              dataReady;

  int     nChecks = 0;
  int     nFails  = 0;
  longint lastOut = 0;
  longint kern [0:255];

  always #5 clk = ~clk;

  sinc3_decim u_sinc3_decim (
    .clk(clk), .rst(rst), .modBit(modBit), .loadRate(loadRate),
    .rateWord(rateWord), .dataOut(dataOut), .dataReady(dataReady)
  );

  task automatic check(string req, bit ok, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // patterns: 0 zeros, 1 ones, 2 alternating, 3 "110", 4 scrambled
  function automatic logic getBit(int pat, int s);
    case (pat)
      0:       return 1'b0;
      1:       return 1'b1;
      2:       return (s % 2) == 0;
      3:       return (s % 3) != 2;
      default: return ((s * s * 7 + s * 13 + 5) % 11) < 5;
    endcase
  endfunction

  function automatic longint xval(int pat, int i);
    if (i < 0) return 0;
    return getBit(pat, i) ? 64'sd1 : -64'sd1;
  endfunction

  task automatic buildKernel(int r);
    longint a [0:255];
    for (int k = 0; k <= 2*r-2; k++)
      a[k] = r - ((k > r-1) ? (k - (r-1)) : ((r-1) - k));
    for (int k = 0; k <= 3*r-3; k++) begin
      kern[k] = 0;
      for (int j = 0; j <= 2*r-2; j++)
        if (j <= k && j >= k-r+1) kern[k] += a[j];
    end
  endtask

  function automatic longint expOut(int pat, int r, int m);
    longint acc = 0;
    int t = (m+1)*r - 1;
    if (pat < 2) return (pat == 1 ? 64'sd1 : -64'sd1) * longint'(r) * r * r;
    for (int k = 0; k <= 3*r-3; k++) acc += kern[k] * xval(pat, t-k);
    return acc;
  endfunction

  // Run nOut valid outputs (plus three settling frames) and check each frame end
  task automatic runStream(string req, bit doLoad, int code, int r, int pat, int nOut);
    int total = (nOut + 3) * r;
    int sFirst;
    if (pat >= 2) buildKernel(r);
    if (doLoad) begin
      @(negedge clk);
      rateWord = RATE_W'(code);
      loadRate = 1'b1;
      modBit   = ~getBit(pat, 0);   // R7: must be discarded
      sFirst   = 0;
    end else begin
      rst    = 1'b0;
      modBit = getBit(pat, 0);
      sFirst = 1;
    end
    for (int s = sFirst; s <= total; s++) begin
      @(negedge clk);
      loadRate = 1'b0;
      if (s > 0) begin
        int idx = s - 1;
        if (((idx + 1) % r) == 0) begin
          int m = (idx + 1) / r - 1;
          if (m >= 3) begin
            longint e = expOut(pat, r, m);
            check(req, dataReady && longint'($signed(dataOut)) == e,
                  longint'($signed(dataOut)), e);
            lastOut = e;
          end else begin
            check("R5 settling", !dataReady && longint'($signed(dataOut)) == lastOut,
                  longint'($signed(dataOut)), lastOut);
          end
        end else if (dataReady) begin
          check("R6 stray ready", 1'b0, 1, 0);
        end
      end else if (dataReady) begin
        check("R7 ready at load", 1'b0, 1, 0);
      end
      if (s < total) modBit = getBit(pat, s);
    end
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R1 reset out", dataOut == '0, longint'($signed(dataOut)), 0);
    check("R1 reset ready", dataReady == 1'b0, dataReady, 0);
    runStream("R1 default rate", 1'b0, 0, 64, 1, 2);
  endtask

  task automatic testPolarity();
    runStream("R2 ones", 1'b1, 40, 40, 1, 2);
    runStream("R2 zeros", 1'b1, 50, 50, 0, 2);
  endtask

  task automatic testPatterns();
    runStream("R3 alternating", 1'b1, 48, 48, 2, 3);
    runStream("R3 period three", 1'b1, 41, 41, 3, 3);
    runStream("R3 scrambled", 1'b1, 64, 64, 4, 3);
    runStream("R3 scrambled r80", 1'b1, 80, 80, 4, 2);
  endtask

  task automatic testClamp();
    runStream("R4 code 5 clamps", 1'b1, 5, 40, 4, 2);
    runStream("R4 code 0 clamps", 1'b1, 0, 40, 3, 2);
  endtask

  task automatic testMidLoad();
    @(negedge clk);
    rateWord = RATE_W'(60);
    loadRate = 1'b1;
    for (int s = 0; s < 130; s++) begin
      @(negedge clk);
      loadRate = 1'b0;
      modBit   = getBit(4, s);
      if (dataReady) check("R9 partial frame ready", 1'b0, 1, 0);
    end
    runStream("R9 restart", 1'b1, 45, 45, 3, 2);
  endtask

  task automatic testFullScale();
    runStream("R8 full positive", 1'b1, 4095, 4095, 1, 1);
    runStream("R8 full negative", 1'b1, 4095, 4095, 0, 1);
  endtask

  bit finished = 1'b0;

  initial begin
    testReset();
    testPolarity();
    testPatterns();
    testClamp();
    testMidLoad();
    testFullScale();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule